// File: doc/BRIEF.md
# Shared Memory Port Cycle Sequencer

This block decides, one memory transaction at a time, what the single memory port of a three-stage 16-bit pipelined processor does next. The port serves three kinds of work. It fetches instructions, it serves DMA transfers and it carries the loads and stores of the execute stage. Every pipeline step begins with a fetch. A pending DMA transfer may add one DMA cycle after it, and a live load or store in the execute stage may add one more cycle after that. The pipeline moves forward only when the last of these transactions completes.

The memory port behaves as a simple handshake. The memory controller raises `mem_rdy` in the clock where the current transaction finishes, and the sequencer starts the next transaction on the following clock. While `mem_rdy` is low the sequencer applies back-pressure to the whole pipeline: every pipeline register holds its value and the sequencer state holds too. When a fetch is followed by a DMA or load/store cycle, the fetched word is parked in a one-word holding register, because the port will carry other data before the pipeline takes that word. The instruction register is then loaded from the holding register and not from the memory data input. As a result the held instruction is never fetched a second time.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset the state output `cyc_state` reads 2'b00 (fetch), `pipe_ce` is low while `mem_rdy` is low, no DMA cycle is pending and `ir_q` is zero.
- R2: The state changes only in a clock where `mem_rdy` is high. `pipe_ce` is never high without `mem_rdy`, and while `mem_rdy` is low `ir_q` keeps its value.
- R3: In the fetch state, when no DMA is pending and no live load/store is in the execute stage, every clock with `mem_rdy` high asserts `pipe_ce`. The instruction register then takes `mem_rdata` directly.
- R4: Within one pipeline step the cycles run in this order: fetch (2'b00), then an optional DMA cycle (2'b01), then an optional load/store cycle (2'b10). A load/store cycle is always followed by a fetch.
- R5: A one-clock pulse on `dma_req` sets a pending flag. The flag is cleared when the DMA cycle completes, unless `dma_req` is high in that clock. A DMA cycle is never followed directly by another DMA cycle, so there is at most one DMA cycle per pipeline step.
- R6: `addr_ce` equals `mem_rdy` in every clock.
- R7: When a fetch completes and a DMA or load/store cycle follows, `hold_ce` pulses and the fetched word is stored. At the end of that step `ir_q` is loaded with the stored word, and `mem_rdata` from the later cycles is ignored.
- R8: The next-cycle qualifiers describe the transaction that follows. `nxt_dbus` is high only when that transaction is a load/store. `nxt_read` is low only when it is a store. `nxt_word` is low only when it is a byte access.
- R9: A load/store in the execute stage with `ex_annul` high never produces a load/store cycle. The fetch completes the step on its own.
- R10: A load with no wait states takes exactly two memory transactions, a fetch and then the load. The instruction fetched in that step reaches `ir_q` without being fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdy | input | 1 | Current memory transaction completes in this clock |
| mem_rdata | input | 16 | Word returned by memory (instruction during a fetch) |
| dma_req | input | 1 | DMA transfer request |
| ex_ldst | input | 1 | Execute-stage instruction is a load or store |
| ex_annul | input | 1 | Execute-stage instruction is annulled |
| ex_byte | input | 1 | Execute-stage access is a byte access |
| ex_store | input | 1 | Execute-stage access is a store |
| pipe_ce | output | 1 | Pipeline clock enable |
| addr_ce | output | 1 | Start the next transaction on the next clock |
| nxt_read | output | 1 | Next transaction is a read |
| nxt_word | output | 1 | Next transaction is 16 bits wide |
| nxt_dbus | output | 1 | Next transaction uses the data bus (load/store) |
| cyc_state | output | 2 | Current cycle kind: 00 fetch, 01 DMA, 10 load/store |
| hold_ce | output | 1 | Capture the fetched word into the holding register |
| ir_sel_hold | output | 1 | Instruction register source is the holding register |
| ir_q | output | 16 | Instruction register |

## Verification
The bench aims at the cycles where the port changes hands. The first is a zero-wait load: a design that lost the prefetched word would put the load data into the instruction register or would need a third transaction. The second is a `dma_req` that stays high: a design that chained DMA cycles would never assert `pipe_ce`. A design that kept the pending flag set after a single pulse would insert DMA cycles nobody asked for. Other cases cover annulled loads that still start a memory cycle, qualifiers taken from the current cycle rather than the next one, and wait states inside DMA and load/store cycles that let the pipeline advance early.

// File: rtl/mem_cycle_seq_pkg.sv
package mem_cycle_seq_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_DMA   = 2'b01,
    CYC_LS    = 2'b10
  } cyc_e;
endpackage

// File: rtl/mcs_dma_pend.sv
module mcs_dma_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~take) | req;
  end

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req) |=> !pend);
endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
  import mem_cycle_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  input  logic dma_pend,
  input  logic ls_pend,
  input  logic ex_store,
  input  logic ex_byte,
  output cyc_e cur,
  output logic pipe_ce,
  output logic hold_ce,
  output logic dma_take,
  output logic sel_hold,
  output logic nxt_read,
  output logic nxt_word,
  output logic nxt_dbus
);
  cyc_e nxt;

  always_comb begin
    nxt = cur;
    if (rdy) begin
      unique case (cur)
        CYC_FETCH: nxt = dma_pend ? CYC_DMA : (ls_pend ? CYC_LS : CYC_FETCH);
        CYC_DMA:   nxt = ls_pend ? CYC_LS : CYC_FETCH;
        default:   nxt = CYC_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= CYC_FETCH;
    else        cur <= nxt;
  end

  always_comb begin
    pipe_ce  = rdy && (nxt == CYC_FETCH);
    hold_ce  = rdy && (cur == CYC_FETCH) && (nxt != CYC_FETCH);
    dma_take = rdy && (cur == CYC_DMA);
    sel_hold = (cur != CYC_FETCH);
    nxt_dbus = (nxt == CYC_LS);
    nxt_read = !((nxt == CYC_LS) && ex_store);
    nxt_word = !((nxt == CYC_LS) && ex_byte);
  end

  // R2
  pce_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_ce |-> rdy);
  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(cur));
  // R5
  no_dma_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == CYC_DMA && rdy) |=> cur != CYC_DMA);
  // R4
  ls_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == CYC_LS && rdy) |=> cur == CYC_FETCH);
endmodule

// File: rtl/mcs_ir_path.sv
module mcs_ir_path #(
  parameter int INSN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_ce,
  input  logic              hold_ce,
  input  logic              sel_hold,
  input  logic [INSN_W-1:0] mem_word,
  output logic [INSN_W-1:0] ir_q
);
  logic [INSN_W-1:0] hold_q;
  logic [INSN_W-1:0] ir_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ce) hold_q <= mem_word;
  end

  assign ir_src = sel_hold ? hold_q : mem_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= '0;
    else if (pipe_ce) ir_q <= ir_src;
  end

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_ce |=> $stable(ir_q));
  // R7
  ir_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_ce && sel_hold) |=> ir_q == $past(hold_q));
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
  import mem_cycle_seq_pkg::*;
#(
  parameter int INSN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rdy,
  input  logic [INSN_W-1:0] mem_rdata,
  input  logic              dma_req,
  input  logic              ex_ldst,
  input  logic              ex_annul,
  input  logic              ex_byte,
  input  logic              ex_store,
  output logic              pipe_ce,
  output logic              addr_ce,
  output logic              nxt_read,
  output logic              nxt_word,
  output logic              nxt_dbus,
  output logic [1:0]        cyc_state,
  output logic              hold_ce,
  output logic              ir_sel_hold,
  output logic [INSN_W-1:0] ir_q
);
  logic dma_pend, dma_take, ls_live;
  cyc_e cur;

  assign ls_live   = ex_ldst & ~ex_annul;
  assign addr_ce   = mem_rdy;
  assign cyc_state = cur;

  mcs_dma_pend u_pend (
    .clk(clk), .rst_n(rst_n), .req(dma_req), .take(dma_take), .pend(dma_pend)
  );

  mcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rdy(mem_rdy), .dma_pend(dma_pend),
    .ls_pend(ls_live), .ex_store(ex_store), .ex_byte(ex_byte), .cur(cur),
    .pipe_ce(pipe_ce), .hold_ce(hold_ce), .dma_take(dma_take),
    .sel_hold(ir_sel_hold), .nxt_read(nxt_read), .nxt_word(nxt_word),
    .nxt_dbus(nxt_dbus)
  );

  mcs_ir_path #(.INSN_W(INSN_W)) u_ir (
    .clk(clk), .rst_n(rst_n), .pipe_ce(pipe_ce), .hold_ce(hold_ce),
    .sel_hold(ir_sel_hold), .mem_word(mem_rdata), .ir_q(ir_q)
  );

  // R9
  annul_no_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rdy && cur != CYC_LS && ex_annul) |=> cur != CYC_LS);
endmodule

// File: tb/mem_cycle_seq_tb_top.sv
module mem_cycle_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_rdy = 1'b0, dma_req = 1'b0, ex_ldst = 1'b0, ex_annul = 1'b0;
  logic ex_byte = 1'b0, ex_store = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic pipe_ce, addr_ce, nxt_read, nxt_word, nxt_dbus, hold_ce, ir_sel_hold;
  logic [1:0] cyc_state;
  logic [15:0] ir_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic mon_arm = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .dma_req(dma_req), .ex_ldst(ex_ldst), .ex_annul(ex_annul),
    .ex_byte(ex_byte), .ex_store(ex_store), .pipe_ce(pipe_ce),
    .addr_ce(addr_ce), .nxt_read(nxt_read), .nxt_word(nxt_word),
    .nxt_dbus(nxt_dbus), .cyc_state(cyc_state), .hold_ce(hold_ce),
    .ir_sel_hold(ir_sel_hold), .ir_q(ir_q)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one clock per call; pushes the fetched word when a fetch completes
  task automatic cyc(input logic rdy, input logic req, input logic ld, input logic an,
                     input logic by, input logic st, input logic [15:0] w,
                     input logic [1:0] est, input logic epce, input logic push,
                     input string tag);
    @(negedge clk);
    mem_rdy = rdy; dma_req = req; ex_ldst = ld; ex_annul = an;
    ex_byte = by; ex_store = st; mem_rdata = w;
    #1;
    chk({tag, " state"}, {14'b0, cyc_state}, {14'b0, est});
    chk({tag, " pipe_ce"}, {15'b0, pipe_ce}, {15'b0, epce});
    chk({"R6 addr_ce"}, {15'b0, addr_ce}, {15'b0, rdy});
    if (push) exp_q.push_back(w);
  endtask

  task automatic qual(input string tag, input logic r, input logic wd, input logic d);
    chk({tag, " nxt_read"}, {15'b0, nxt_read}, {15'b0, r});
    chk({tag, " nxt_word"}, {15'b0, nxt_word}, {15'b0, wd});
    chk({tag, " nxt_dbus"}, {15'b0, nxt_dbus}, {15'b0, d});
  endtask

  // monitor: after each pipeline advance, the instruction register must hold the next expected word
  always @(negedge clk) begin
    #2;
    if (mon_arm) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3/R7 ir_q actual=%h expected=<none>", ir_q);
      end else begin
        chk("R3/R7/R10 ir_q", ir_q, exp_q.pop_front());
      end
    end
    mon_arm = pipe_ce;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", {14'b0, cyc_state}, 16'h0);
    chk("R1 reset pipe_ce", {15'b0, pipe_ce}, 16'h0);
    chk("R1 reset ir_q", ir_q, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0,0,0,0,0,0,16'h0000, 2'b00, 0, 0, "R1 idle");

    // plain fetches (R3)
    cyc(1,0,0,0,0,0,16'h1111, 2'b00, 1, 1, "R3 fetch");
    qual("R8 fetch", 1, 1, 0);
    cyc(1,0,0,0,0,0,16'h2222, 2'b00, 1, 1, "R3 fetch");
    // wait states (R2)
    cyc(0,0,0,0,0,0,16'hBAD0, 2'b00, 0, 0, "R2 wait");
    cyc(0,0,0,0,0,0,16'hBAD1, 2'b00, 0, 0, "R2 wait");
    chk("R2 ir holds", ir_q, 16'h2222);
    cyc(1,0,0,0,0,0,16'h3333, 2'b00, 1, 1, "R2 fetch after wait");

    // zero-wait load: fetch then load, two transactions (R10, R7)
    cyc(1,0,1,0,0,0,16'h4444, 2'b00, 0, 1, "R10 load fetch");
    qual("R8 load next", 1, 1, 1);
    chk("R7 hold_ce", {15'b0, hold_ce}, 16'h1);
    cyc(1,0,1,0,0,0,16'hDEAD, 2'b10, 1, 0, "R10 load cycle");
    chk("R7 sel_hold", {15'b0, ir_sel_hold}, 16'h1);
    qual("R8 after load", 1, 1, 0);
    cyc(1,0,0,0,0,0,16'h5555, 2'b00, 1, 1, "R10 next fetch");

    // byte store qualifiers (R8)
    cyc(1,0,1,0,1,1,16'h6666, 2'b00, 0, 1, "R8 store fetch");
    qual("R8 byte store next", 0, 0, 1);
    cyc(0,0,1,0,1,1,16'hDEAD, 2'b10, 0, 0, "R2 store wait");
    cyc(1,0,1,0,1,1,16'hDEAD, 2'b10, 1, 0, "R4 store cycle");

    // DMA pulse then load: fetch, DMA, LS order (R4, R5)
    cyc(0,1,0,0,0,0,16'h0000, 2'b00, 0, 0, "R5 req pulse");
    cyc(1,0,1,0,0,0,16'h7777, 2'b00, 0, 1, "R4 fetch w/ dma");
    qual("R8 dma next", 1, 1, 0);
    cyc(0,0,1,0,0,0,16'hBEEF, 2'b01, 0, 0, "R4 dma wait");
    cyc(1,0,1,0,0,0,16'hBEEF, 2'b01, 0, 0, "R4 dma done");
    qual("R8 dma to ls", 1, 1, 1);
    cyc(1,0,1,0,0,0,16'hDEAD, 2'b10, 1, 0, "R4 ls after dma");
    cyc(1,0,0,0,0,0,16'h8888, 2'b00, 1, 1, "R5 pend cleared");

    // held request: at most one DMA per step (R5)
    cyc(1,1,0,0,0,0,16'h9999, 2'b00, 1, 1, "R5 req first clk");
    cyc(1,1,0,0,0,0,16'hAAAA, 2'b00, 0, 1, "R5 fetch then dma");
    cyc(1,1,0,0,0,0,16'hBEEF, 2'b01, 1, 0, "R5 single dma");
    cyc(1,0,0,0,0,0,16'hBBBB, 2'b00, 0, 1, "R5 dma again");
    cyc(1,0,0,0,0,0,16'hBEEF, 2'b01, 1, 0, "R5 last dma");
    cyc(1,0,0,0,0,0,16'hCCCC, 2'b00, 1, 1, "R5 no more dma");

    // annulled load (R9)
    cyc(1,0,1,1,0,0,16'hDDDD, 2'b00, 1, 1, "R9 annulled ld");
    qual("R9 no ls", 1, 1, 0);
    cyc(1,0,0,0,0,0,16'hEEEE, 2'b00, 1, 1, "R9 fetch");

    cyc(0,0,0,0,0,0,16'h0000, 2'b00, 0, 0, "drain");
    cyc(0,0,0,0,0,0,16'h0000, 2'b00, 0, 0, "drain");
    chk("R7 queue empty", exp_q.size()[15:0], 16'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule